// File: doc/BRIEF.md
# UART Interrupt Status and Clear Controller

This block keeps the interrupt state of a UART whose shifter, baud generator and FIFO storage sit elsewhere. It watches the transmit and receive FIFO fill levels against programmable trigger levels. It also watches a strobe that marks the final data bit leaving the transmitter, and two modem-line change strobes (data-set-ready and carrier-detect). From these events it sets sticky raw status bits. Software sees those bits through a small register bus.

Each raw bit is cleared by a write-one command, or automatically by FIFO activity. With the FIFO enabled, a level that moves back across the trigger clears the bit. With the FIFO disabled, a single byte transfer clears it. An end-of-transmission mode bit selects what raises the transmit interrupt: a FIFO threshold crossing or the end-of-last-bit strobe. A per-bit enable register selects which raw bits reach the masked status word. The masked word is ORed into one registered interrupt line. All pins are plain control and status signals: no data stream passes through the block, so there is no valid/ready handshake.

Register bus: a write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is a combinational readback of the register selected by `bus_addr`. The addresses are 0 for the enable register (read/write), 1 for raw status (read-only), 2 for masked status (read-only) and 3 for the write-one clear register (reads 0).

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the enable register, raw status, masked status and `irq` are all 0.
- R2: With `eot_mode`=0 and the FIFO enabled, the transmit raw bit (bit 5) sets at the clock edge where `tx_level` moves from above `tx_trig` to at or below it.
- R3: With `eot_mode`=1, a `tx_done` pulse sets bit 5 at the next edge, and transmit level crossings do not set it.
- R4: With the FIFO enabled, the receive raw bit (bit 4) sets at the edge where `rx_level` moves from below `rx_trig` to at or above it.
- R5: Writing to address 3 clears each raw bit whose data bit is 1, and leaves bits written 0 unchanged. If a set event and a clear fall in the same cycle, the bit ends up set.
- R6: With the FIFO enabled, bit 5 clears when `tx_level` rises from at-or-below `tx_trig` to above it. Bit 4 clears when `rx_level` falls from at-or-above `rx_trig` to below it.
- R7: With the FIFO disabled, bit 5 sets when `tx_level` drops to 0 and clears on a `tx_push` pulse. Bit 4 sets when `rx_level` rises from 0 and clears on an `rx_pop` pulse.
- R8: `dsr_chg` sets bit 3 and `dcd_chg` sets bit 2. Only a write-one to address 3 clears them; FIFO activity does not.
- R9: The enable register at address 0 keeps only bits 5..2; all other bits read 0. Address 2 reads raw AND enable.
- R10: `irq` is the OR of the masked status word, delayed by one clock.
- R11: With `MODEM_EN`=0, bits 3 and 2 read 0 at every address and cannot be enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| eot_mode | input | 1 | Transmit interrupt on last bit out instead of threshold |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_push | input | 1 | Pulse: byte written to transmit path |
| rx_pop | input | 1 | Pulse: byte read from receive path |
| tx_done | input | 1 | Pulse: final data bit shifted out |
| dsr_chg | input | 1 | Pulse: data-set-ready line changed |
| dcd_chg | input | 1 | Pulse: carrier-detect line changed |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest case is a set event and a write-one clear that land on the same edge. An instance is a receive level climbing across its trigger in the very cycle software clears bit 4. A directed step produces this collision on purpose. The random phase also produces it often: level walks, strobes and bus writes all run together, and the bench model predicts every edge. Mode and trigger changes made while a FIFO level is non-zero give a second class of crossings that are hard to reach. The random walk covers these as well.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int TX_BIT  = 5;
  localparam int RX_BIT  = 4;
  localparam int DSR_BIT = 3;
  localparam int DCD_BIT = 2;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_RAW    = 2'd1,
    ADDR_MASKED = 2'd2,
    ADDR_CLEAR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uirq_level_mon.sv
module uirq_level_mon #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W:0]   thr,
  output logic             went_up,
  output logic             went_down
);
  logic [LVL_W-1:0] prev_q;
  logic [LVL_W:0]   cur_w, prev_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign cur_w     = {1'b0, level};
  assign prev_w    = {1'b0, prev_q};
  assign went_up   = (prev_w < thr) && (cur_w >= thr);
  assign went_down = (prev_w >= thr) && (cur_w < thr);
endmodule

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/uirq_regfile.sv
module uirq_regfile
  import uirq_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] VALID_BITS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] raw_word,
  output logic [DATA_W-1:0] masked_word,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              w1c_hit
);
  reg_addr_e         addr;
  logic [DATA_W-1:0] enable_q;

  assign addr = reg_addr_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_q <= '0;
    else if (bus_wr && addr == ADDR_ENABLE)
      enable_q <= bus_wdata & VALID_BITS;
  end

  assign masked_word = raw_word & enable_q;
  assign w1c_hit     = bus_wr && (addr == ADDR_CLEAR);

  always_comb begin
    unique case (addr)
      ADDR_ENABLE: bus_rdata = enable_q;
      ADDR_RAW:    bus_rdata = raw_word;
      ADDR_MASKED: bus_rdata = masked_word;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int DATA_W   = 8,
  parameter bit MODEM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              eot_mode,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_trig,
  input  logic [LVL_W-1:0]  rx_trig,
  input  logic              tx_push,
  input  logic              rx_pop,
  input  logic              tx_done,
  input  logic              dsr_chg,
  input  logic              dcd_chg,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NSRC      = MODEM_EN ? 4 : 2;
  localparam int VALID_INT = (1 << TX_BIT) | (1 << RX_BIT) |
                             (MODEM_EN ? ((1 << DSR_BIT) | (1 << DCD_BIT)) : 0);
  localparam logic [DATA_W-1:0] VALID_BITS = VALID_INT[DATA_W-1:0];
  localparam logic [LVL_W:0]    THR_ONE    = 1;
  localparam int SRC_POS [4] = '{TX_BIT, RX_BIT, DSR_BIT, DCD_BIT};

  logic [LVL_W:0]    tx_thr, rx_thr;
  logic              tx_up, tx_dn, rx_up, rx_dn;
  logic [3:0]        src_set, src_clr, src_q;
  logic [DATA_W-1:0] raw_word, masked_word;
  logic              w1c_hit;

  // Threshold of a level monitor: "at or above thr" counts as crossed.
  assign tx_thr = fifo_en ? ({1'b0, tx_trig} + THR_ONE) : THR_ONE;
  assign rx_thr = fifo_en ? {1'b0, rx_trig} : THR_ONE;

  uirq_level_mon #(.LVL_W(LVL_W)) u_tx_mon (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(tx_thr),
    .went_up(tx_up), .went_down(tx_dn)
  );

  uirq_level_mon #(.LVL_W(LVL_W)) u_rx_mon (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rx_thr),
    .went_up(rx_up), .went_down(rx_dn)
  );

  always_comb begin
    src_set[0] = eot_mode ? tx_done : tx_dn;
    src_set[1] = rx_up;
    src_set[2] = dsr_chg;
    src_set[3] = dcd_chg;
    src_clr[0] = (w1c_hit && bus_wdata[TX_BIT])  || (fifo_en ? tx_up : tx_push);
    src_clr[1] = (w1c_hit && bus_wdata[RX_BIT])  || (fifo_en ? rx_dn : rx_pop);
    src_clr[2] = w1c_hit && bus_wdata[DSR_BIT];
    src_clr[3] = w1c_hit && bus_wdata[DCD_BIT];
  end

  for (genvar s = 0; s < 4; s++) begin : g_src
    if (s < NSRC) begin : g_on
      uirq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(src_set[s]), .clr_i(src_clr[s]),
        .q(src_q[s])
      );
    end else begin : g_off
      assign src_q[s] = 1'b0;
    end
  end

  always_comb begin
    raw_word = '0;
    for (int s = 0; s < 4; s++) raw_word[SRC_POS[s]] = src_q[s];
  end

  uirq_regfile #(.DATA_W(DATA_W), .VALID_BITS(VALID_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw_word(raw_word), .masked_word(masked_word),
    .bus_rdata(bus_rdata), .w1c_hit(w1c_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked_word;
  end
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eot_mode,
  input logic              tx_done,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [3:0]        src_set,
  input logic [3:0]        src_q,
  input logic [DATA_W-1:0] masked_word,
  input logic              irq
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == 2'd3);

  AST_EOT_IGNORES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && !tx_done && !src_q[0]) |=> !src_q[0]);  // R3
  AST_DONE_SETS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && tx_done) |=> src_q[0]);  // R3
  AST_W1C_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[4] && !src_set[1]) |=> !src_q[1]);  // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    src_set[1] |=> src_q[1]);  // R5
  AST_DSR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q[2] && !(clr_wr && bus_wdata[3])) |=> src_q[2]);  // R8
  AST_IRQ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|masked_word)));  // R10
endmodule

bind uart_irq_ctrl uirq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eot_mode(eot_mode), .tx_done(tx_done),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .src_set(src_set), .src_q(src_q), .masked_word(masked_word), .irq(irq)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, eot_mode = 1'b0;
  logic [4:0] tx_level = '0, rx_level = '0, tx_trig = 5'd4, rx_trig = 5'd4;
  logic       tx_push = 0, rx_pop = 0, tx_done = 0, dsr_chg = 0, dcd_chg = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata, nm_rdata;
  logic       irq, nm_irq;

  int checks = 0, errors = 0;
  logic [7:0] m_raw = '0, m_mask = '0;
  logic       m_irq = 0, m_irq_nm = 0;
  int         m_ptx = 0, m_prx = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
    .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .tx_push(tx_push), .rx_pop(rx_pop), .tx_done(tx_done), .dsr_chg(dsr_chg),
    .dcd_chg(dcd_chg), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  uart_irq_ctrl #(.MODEM_EN(1'b0)) uut_nomodem (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
    .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .tx_push(tx_push), .rx_pop(rx_pop), .tx_done(tx_done), .dsr_chg(dsr_chg),
    .dcd_chg(dcd_chg), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(nm_rdata), .irq(nm_irq)
  );

  function automatic logic [7:0] exp_read(logic [1:0] a, logic [7:0] raw,
                                          logic [7:0] msk, logic [7:0] valid);
    case (a)
      2'd0:    return msk & valid;
      2'd1:    return raw & valid;
      2'd2:    return raw & msk & valid;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle with the currently driven inputs; model predicts the edge.
  task automatic tick(string tag);
    int thr_t, thr_r;
    logic t_up, t_dn, r_up, r_dn, w1c;
    logic [7:0] n_raw, n_mask;
    logic [3:0] setv, clrv;
    thr_t = fifo_en ? int'(tx_trig) + 1 : 1;
    thr_r = fifo_en ? int'(rx_trig) : 1;
    t_up = (m_ptx < thr_t) && (int'(tx_level) >= thr_t);
    t_dn = (m_ptx >= thr_t) && (int'(tx_level) < thr_t);
    r_up = (m_prx < thr_r) && (int'(rx_level) >= thr_r);
    r_dn = (m_prx >= thr_r) && (int'(rx_level) < thr_r);
    w1c  = bus_wr && bus_addr == 2'd3;
    setv = {dcd_chg, dsr_chg, r_up, eot_mode ? tx_done : t_dn};
    clrv[0] = (w1c && bus_wdata[5]) || (fifo_en ? t_up : tx_push);
    clrv[1] = (w1c && bus_wdata[4]) || (fifo_en ? r_dn : rx_pop);
    clrv[2] = w1c && bus_wdata[3];
    clrv[3] = w1c && bus_wdata[2];
    n_raw = m_raw;
    for (int s = 0; s < 4; s++) begin
      if (setv[s])      n_raw[5-s] = 1'b1;
      else if (clrv[s]) n_raw[5-s] = 1'b0;
    end
    n_mask = (bus_wr && bus_addr == 2'd0) ? (bus_wdata & 8'h3C) : m_mask;
    @(posedge clk); #1;
    if (!rst_n) begin
      m_raw = '0; m_mask = '0; m_irq = 0; m_irq_nm = 0; m_ptx = 0; m_prx = 0;
    end else begin
      m_irq    = |(m_raw & m_mask);
      m_irq_nm = |(m_raw & m_mask & 8'h30);
      m_raw = n_raw; m_mask = n_mask;
      m_ptx = int'(tx_level); m_prx = int'(rx_level);
    end
    chk({tag, " rdata"}, rdata, exp_read(bus_addr, m_raw, m_mask, 8'h3C));
    chk({tag, " irq"}, irq, m_irq);
    chk({tag, " R11 rdata"}, nm_rdata, exp_read(bus_addr, m_raw, m_mask, 8'h30));
    chk({tag, " R11 irq"}, nm_irq, m_irq_nm);
    tx_push = 0; rx_pop = 0; tx_done = 0; dsr_chg = 0; dcd_chg = 0; bus_wr = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick(tag);
    bus_addr = 2'd1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tl, rl;
    void'($urandom(32'd2718));
    repeat (3) tick("R1 reset");
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); tick("R1");
      chk("R1 zero after reset", rdata, 0);
    end
    bus_addr = 2'd1;
    // R2 / R6 transmit threshold
    tx_level = 8; tick("R6");
    tx_level = 3; tick("R2"); chk("R2 tx set", rdata[5], 1);
    tx_level = 8; tick("R6"); chk("R6 tx autoclear", rdata[5], 0);
    // R3 end-of-transmission mode
    eot_mode = 1; tx_level = 3; tick("R3"); chk("R3 level ignored", rdata[5], 0);
    tx_done = 1; tick("R3"); chk("R3 done sets", rdata[5], 1);
    eot_mode = 0; tx_level = 8; tick("R6"); chk("R6 tx clear", rdata[5], 0);
    // R4 / R5 receive and clear register
    rx_level = 5; tick("R4"); chk("R4 rx set", rdata[4], 1);
    wr(2'd3, 8'h00, "R5"); tick("R5"); chk("R5 write zero no effect", rdata[4], 1);
    wr(2'd3, 8'h10, "R5"); tick("R5"); chk("R5 w1c", rdata[4], 0);
    rx_level = 2; tick("R6");
    rx_level = 5; wr(2'd3, 8'h10, "R5"); tick("R5"); chk("R5 set wins", rdata[4], 1);
    rx_level = 2; tick("R6"); chk("R6 rx autoclear", rdata[4], 0);
    // R8 modem sources
    dsr_chg = 1; tick("R8"); chk("R8 dsr set", rdata[3], 1);
    chk("R11 dsr absent", nm_rdata[3:2], 0);
    rx_level = 5; tick("R8"); rx_level = 2; tick("R8");
    chk("R8 dsr survives fifo activity", rdata[3], 1);
    dcd_chg = 1; tick("R8"); chk("R8 dcd set", rdata[2], 1);
    wr(2'd3, 8'h08, "R8"); tick("R8"); chk("R8 dsr w1c", rdata[3:2], 2'b01);
    wr(2'd3, 8'h04, "R8"); tick("R8"); chk("R8 dcd w1c", rdata[2], 0);
    // R9 / R10 enable register and irq timing
    bus_addr = 2'd0; bus_wdata = 8'hFF; bus_wr = 1; tick("R9");
    chk("R9 enable readback", rdata, 8'h3C); chk("R11 enable readback", nm_rdata, 8'h30);
    bus_addr = 2'd1;
    rx_level = 5; tick("R10"); chk("R10 irq not yet", irq, 0);
    bus_addr = 2'd2; tick("R9"); chk("R9 masked word", rdata, 8'h10);
    chk("R10 irq one late", irq, 1);
    bus_addr = 2'd1;
    // R7 FIFO disabled
    rx_level = 0; tick("R7"); tx_level = 0; tick("R7");
    fifo_en = 0; tx_level = 1; tick("R7");
    tx_push = 1; tick("R7"); chk("R7 push clears tx", rdata[5], 0);
    tx_level = 0; tick("R7"); chk("R7 empty sets tx", rdata[5], 1);
    tx_push = 1; tick("R7"); chk("R7 push clears tx again", rdata[5], 0);
    rx_level = 1; tick("R7"); chk("R7 byte sets rx", rdata[4], 1);
    rx_pop = 1; tick("R7"); chk("R7 pop clears rx", rdata[4], 0);
    // Random phase across R2..R11
    tl = int'(tx_level); rl = int'(rx_level);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 63) == 0) eot_mode = ~eot_mode;
      if ($urandom_range(0, 99) == 0) tx_trig = 5'($urandom_range(1, 15));
      if ($urandom_range(0, 99) == 0) rx_trig = 5'($urandom_range(1, 15));
      tl += int'($urandom_range(0, 2)) - 1; if (tl < 0) tl = 0; if (tl > 16) tl = 16;
      rl += int'($urandom_range(0, 2)) - 1; if (rl < 0) rl = 0; if (rl > 16) rl = 16;
      tx_level = 5'(tl); rx_level = 5'(rl);
      tx_push = ($urandom_range(0, 7) == 0); rx_pop = ($urandom_range(0, 7) == 0);
      tx_done = ($urandom_range(0, 7) == 0);
      dsr_chg = ($urandom_range(0, 15) == 0); dcd_chg = ($urandom_range(0, 15) == 0);
      bus_addr = 2'($urandom_range(0, 3));
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_wdata = 8'($urandom);
      tick("R2-random R4 R5 R6 R7 R8 R9 R10");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule